// File: doc/BRIEF.md
# DisplayPort Sink Capability Register File

This block is a byte-wide register store that stands in for the capability and status space of an attached display. A DisplayPort AUX transaction engine sees it as the far end of the link. The engine issues single-byte reads and writes over a simple synchronous request port. The address space is 19 bits wide, which covers 512 KiB. Only the lowest 0x600 bytes hold storage. Any access above that region completes normally, but it raises a one-cycle bad-offset pulse. Reads there return zero, and writes there are discarded.

On a synchronous active-low reset, every backed byte is cleared. A small set of bytes is then given preset values in the same cycle. The presets describe a sink whose four-lane link is already trained: every lane reports clock recovery, equalization and symbol lock, and inter-lane alignment is reported as done. Software may overwrite any backed byte, including the presets, and reads it back unchanged.

Top module: `dp_sink_regfile`

## Requirements
- R1: A read request (req_valid=1, req_write=0) to an offset below 0x600 returns the stored byte on rsp_rdata in the cycle after the request, with rsp_valid high in that cycle.
- R2: rsp_valid is high only in the cycle directly after a read request; write requests and idle cycles produce rsp_valid=0, and rsp_rdata is 0x00 whenever rsp_valid is 0.
- R3: A read at any offset from 0x600 to 0x7FFFF returns 0x00 with rsp_valid high.
- R4: A write at any offset of 0x600 or above changes no backed byte.
- R5: bad_offset pulses high for exactly the cycle after any request, read or write, whose offset is 0x600 or above, and is low otherwise.
- R6: After reset, every backed byte reads 0x00 except the preset bytes of R7 and R8.
- R7: After reset, these presets apply: offset 0x000 (revision) = 0x10, 0x001 (maximum link rate) = 0x14, 0x002 (maximum lane count) = 0x04, 0x008 (receive port 0 capability 0, EDID-present is bit 1) = 0x02, 0x009 (receive port 0 buffer size) = 0xFF, 0x204 (inter-lane alignment done in bit 0) = 0x01, and 0x205 (receive port 0 in sync in bit 0) = 0x01.
- R8: After reset, the lane status bytes at 0x202 (lanes 0 and 1) and 0x203 (lanes 2 and 3) both read 0x77. Bits 0, 1 and 2 hold clock-recovery done, equalization done and symbol locked for the lower lane, and bits 4, 5 and 6 hold the same flags for the upper lane.
- R9: A write below 0x600 stores its byte verbatim, including at preset offsets, and a read issued in the next cycle returns it.
- R10: Asserting reset after writes restores the full profile of R6 to R8 before the first request that follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte offset |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Read byte, one cycle after the read |
| rsp_valid | output | 1 | Read response strobe |
| bad_offset | output | 1 | Pulse for an access at or above 0x600 |

## Verification
The assertions check the timing rules on every cycle. A response follows each read and only a read, idle read data is zero, out-of-range reads return zero, the bad-offset pulse follows exactly the out-of-range accesses, and the storage write enable never fires outside the backed region. Storage contents are checked only by the bench's scenarios. These cover the preset profile after each reset, verbatim write-back over the whole backed region including the presets, and the absence of any change after out-of-range writes. Each of these needs a sweep of reads compared against values computed in the bench.

// File: rtl/dpsink_pkg.sv
// Package: dpsink_pkg
// Holds the shared sizes of the sink register file and the reset profile
// function. Assumes byte-wide data; presets are expressed as byte values.
package dpsink_pkg;
    localparam int SINK_ADDR_W  = 19;
    localparam int SINK_DATA_W  = 8;
    localparam int SINK_BACKED  = 1536;

    localparam int OFS_REVISION   = 'h000;
    localparam int OFS_LINK_RATE  = 'h001;
    localparam int OFS_LANE_COUNT = 'h002;
    localparam int OFS_RX0_CAP0   = 'h008;
    localparam int OFS_RX0_CAP1   = 'h009;
    localparam int OFS_LANE01     = 'h202;
    localparam int OFS_LANE23     = 'h203;
    localparam int OFS_ALIGN      = 'h204;
    localparam int OFS_SINK_STAT  = 'h205;

    // Per-lane flags: bit0 clock recovery, bit1 equalization, bit2 symbol lock.
    localparam logic [3:0] LANE_TRAINED = 4'b0111;

    // Reset value of one backed byte; every byte not listed is zero.
    function automatic logic [SINK_DATA_W-1:0] preset_byte(input int ofs);
        logic [SINK_DATA_W-1:0] v;
        case (ofs)
            OFS_REVISION:   v = 8'h10;
            OFS_LINK_RATE:  v = 8'h14;
            OFS_LANE_COUNT: v = 8'h04;
            OFS_RX0_CAP0:   v = 8'h02;
            OFS_RX0_CAP1:   v = 8'hFF;
            OFS_LANE01,
            OFS_LANE23:     v = {LANE_TRAINED, LANE_TRAINED};
            OFS_ALIGN:      v = 8'h01;
            OFS_SINK_STAT:  v = 8'h01;
            default:        v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/dpsink_addr_decode.sv
// Module: dpsink_addr_decode
// Splits a byte offset into an in-range flag and a storage index.
// Assumes DEPTH <= 2**AW; when DEPTH fills the space every offset is in range.
module dpsink_addr_decode #(
    parameter int AW    = 19,
    parameter int DEPTH = 1536,
    parameter int IW    = 11
) (
    input  logic [AW-1:0] addr,
    output logic          in_range,
    output logic [IW-1:0] index
);
    generate
        if (DEPTH >= (2 ** AW)) begin : g_full
            // Whole space backed: nothing is out of range.
            assign in_range = 1'b1;
        end else begin : g_sparse
            // Sparse map: compare against the backed size.
            assign in_range = (addr < AW'(DEPTH));
        end
    endgenerate

    // Low bits address the storage array.
    assign index = addr[IW-1:0];
endmodule

// File: rtl/dpsink_store.sv
// Module: dpsink_store
// Byte storage for the backed region, with the reset profile loaded in the
// reset cycle. Assumes the caller only raises wr_en for indices below DEPTH.
module dpsink_store
    import dpsink_pkg::*;
#(
    parameter int DEPTH = 1536,
    parameter int IW    = 11,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Clear-and-preset on reset, otherwise store the written byte verbatim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DW'(preset_byte(i));
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Asynchronous read of the addressed byte; the caller registers it.
    assign rd_data = mem[rd_idx];

    AST_WR_IN_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < (IW+1)'(DEPTH))); // R4
endmodule

// File: rtl/dp_sink_regfile.sv
// Module: dp_sink_regfile
// Sink capability/status register file seen by an AUX transaction engine.
// One byte per request; read data and the bad-offset pulse are registered
// and appear one cycle after the request. Synchronous active-low reset.
module dp_sink_regfile
    import dpsink_pkg::*;
#(
    parameter int ADDR_W = SINK_ADDR_W,
    parameter int DATA_W = SINK_DATA_W,
    parameter int BACKED = SINK_BACKED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_valid,
    output logic              bad_offset
);
    localparam int IDX_W = $clog2(BACKED);

    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] store_rd;
    logic              rd_req;
    logic              wr_req;

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write && hit;

    dpsink_addr_decode #(
        .AW    (ADDR_W),
        .DEPTH (BACKED),
        .IW    (IDX_W)
    ) decode_i (
        .addr     (req_addr),
        .in_range (hit),
        .index    (idx)
    );

    dpsink_store #(
        .DEPTH (BACKED),
        .IW    (IDX_W),
        .DW    (DATA_W)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_req),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .rd_idx  (idx),
        .rd_data (store_rd)
    );

    // Register the response strobe, read byte and bad-offset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            bad_offset <= 1'b0;
        end else begin
            rsp_valid  <= rd_req;
            rsp_rdata  <= (rd_req && hit) ? store_rd : '0;
            bad_offset <= req_valid && !hit;
        end
    end

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R1
    AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R2
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0)); // R2
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr >= ADDR_W'(BACKED)) |=> (rsp_rdata == '0)); // R3
    AST_BAD_ON_OOR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= ADDR_W'(BACKED)) |=> bad_offset); // R5
    AST_NO_BAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_addr >= ADDR_W'(BACKED)) |=> !bad_offset); // R5
endmodule

// File: tb/dp_sink_regfile_tb_top.sv
// Bench: sweeps the whole backed region against presets and written patterns.
module dp_sink_regfile_tb_top;
    localparam int BACKED = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_valid;
    logic        bad_offset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dp_sink_regfile dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_rdata  (rsp_rdata),
        .rsp_valid  (rsp_valid),
        .bad_offset (bad_offset)
    );

    function automatic logic [7:0] exp_preset(input int a);
        case (a)
            'h000: return 8'h10;
            'h001: return 8'h14;
            'h002: return 8'h04;
            'h008: return 8'h02;
            'h009: return 8'hFF;
            'h202: return 8'h77;
            'h203: return 8'h77;
            'h204: return 8'h01;
            'h205: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37) + (a >> 4) + 8'h5A);
    endfunction

    function automatic string req_of(input int a);
        if (a == 'h202 || a == 'h203) return "R8";
        if (exp_preset(a) != 8'h00) return "R7";
        return "R6";
    endfunction

    task automatic chk(input string rq, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    // One request; outputs sampled at the following negedge.
    task automatic access(input bit we, input int a, input logic [7:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = we;
        req_addr  = 19'(a);
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic read_chk(input int a, input logic [7:0] exp, input string rq);
        access(1'b0, a, 8'h00);
        chk(rq, rsp_valid === 1'b1, int'(rsp_valid), 1);
        chk(rq, rsp_rdata === exp, int'(rsp_rdata), int'(exp));
        chk("R5", bad_offset === (a >= BACKED), int'(bad_offset), int'(a >= BACKED));
    endtask

    task automatic write_chk(input int a, input logic [7:0] wd);
        access(1'b1, a, wd);
        chk("R2", rsp_valid === 1'b0, int'(rsp_valid), 0);
        chk("R2", rsp_rdata === 8'h00, int'(rsp_rdata), 0);
        chk("R5", bad_offset === (a >= BACKED), int'(bad_offset), int'(a >= BACKED));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sweep_presets(input string tag);
        for (int a = 0; a < BACKED; a++) begin
            read_chk(a, exp_preset(a), (tag == "") ? req_of(a) : tag);
        end
    endtask

    initial begin
        do_reset();
        // Reset state at the ports before any request.
        chk("R2", rsp_valid === 1'b0, int'(rsp_valid), 0);
        chk("R5", bad_offset === 1'b0, int'(bad_offset), 0);
        chk("R2", rsp_rdata === 8'h00, int'(rsp_rdata), 0);

        // R6/R7/R8: full preset profile after reset, read through R1 path.
        sweep_presets("");

        // R2: idle cycle yields no response.
        @(negedge clk);
        chk("R2", rsp_valid === 1'b0, int'(rsp_valid), 0);

        // R9: write the whole backed region with a pattern, read it back.
        for (int a = 0; a < BACKED; a++) write_chk(a, pattern(a));
        for (int a = 0; a < BACKED; a++) read_chk(a, pattern(a), "R9");

        // R9: presets overwritten and read in the very next cycle.
        write_chk('h202, 8'h00);
        read_chk('h202, 8'h00, "R9");
        write_chk('h000, 8'hA5);
        read_chk('h000, 8'hA5, "R9");

        // R4/R5: out-of-range writes, aliasing low addresses too.
        write_chk('h600, 8'h11);
        write_chk('h7FF, 8'h22);
        write_chk('h800, 8'h33);
        write_chk('h40000, 8'h44);
        write_chk('h7FFFF, 8'h55);
        write_chk('h40202, 8'h66);
        for (int a = 0; a < BACKED; a++) begin
            logic [7:0] e;
            e = pattern(a);
            if (a == 'h202) e = 8'h00;
            if (a == 'h000) e = 8'hA5;
            read_chk(a, e, "R4");
        end

        // R3/R5: out-of-range reads return zero and flag the offset.
        read_chk('h600, 8'h00, "R3");
        read_chk('h601, 8'h00, "R3");
        read_chk('h800, 8'h00, "R3");
        read_chk('h40000, 8'h00, "R3");
        read_chk('h7FFFF, 8'h00, "R3");
        for (int k = 0; k < 19; k++) begin
            if ((1 << k) >= BACKED) read_chk(1 << k, 8'h00, "R3");
        end
        // R5: the pulse lasts one cycle.
        @(negedge clk);
        chk("R5", bad_offset === 1'b0, int'(bad_offset), 0);

        // R10: reset restores the profile after all the writes.
        do_reset();
        sweep_presets("R10");

        done = 1'b1;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
        end
    end

    initial begin
        wait (done);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150001) @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule